// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This unit multiplies two signed 16-bit fractions (Q15) and stores or adds the result in a 36-bit signed fixed-point accumulator. The accumulator keeps 31 fractional bits below its radix point and five bits above it: one sign bit and four guard bits. Running sums can therefore reach about ±16 before they wrap. A single start strobe launches one operation, chosen by a 2-bit code: clear, load, multiply-only or multiply-accumulate. The unit is fully pipelined, so a new operation may start on every clock. Each operation lands in the accumulator exactly two clocks after its start, and a one-cycle done pulse marks that moment.

With each start, the unit also takes a byte holding two packed 4-bit two's-complement pointer steps. It presents them sign-extended to 16 bits, aligned with done, so the address update that follows can use them directly. Operand fetch, instruction decode and repeat control are left to the surrounding logic.

Top module: `fmac_unit`

## Requirements
- R1: Operation code 2'b10 (multiply-only) sets the accumulator to the Q15×Q15 product shifted left one place (Q31) and sign-extended to 36 bits; ovf_o reads 0 after it.
- R2: Operation code 2'b11 (multiply-accumulate) adds the same 36-bit Q31 product to the current accumulator value; back-to-back accumulates on consecutive clocks each see the previous result.
- R3: The product of 16'h8000 and 16'h8000 is +1.0, i.e. 36'h0_8000_0000, with no saturation and no sign error.
- R4: Operation code 2'b00 (clear) sets the accumulator to zero and ovf_o to 0.
- R5: Operation code 2'b01 (load) sets the accumulator to the 32-bit value {opa_i, opb_i} sign-extended to 36 bits; ovf_o reads 0 after it.
- R6: A multiply-accumulate whose true sum lies outside −2^35 … 2^35−1 sets ovf_o to 1 and leaves the sum wrapped modulo 2^36; a multiply-accumulate without overflow sets ovf_o to 0.
- R7: done_o is high for exactly one clock, two clocks after the clock on which start_i was sampled high; acc_o and ovf_o change only in a cycle in which done_o is high.
- R8: When done_o is high, xofs_o is bits [7:4] of the ofs_i byte given with that start, and yofs_o is bits [3:0]; each is sign-extended to 16 bits.
- R9: After reset, acc_o, ovf_o, done_o, xofs_o and yofs_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch one operation this clock |
| op_i | input | 2 | Operation: 00 clear, 01 load, 10 multiply, 11 multiply-accumulate |
| opa_i | input | 16 | Q15 multiplicand, or the high word for a load |
| opb_i | input | 16 | Q15 multiplier, or the low word for a load |
| ofs_i | input | 8 | Packed pointer steps: X in [7:4], Y in [3:0] |
| acc_o | output | 36 | Accumulator, Q31 with four guard bits |
| ovf_o | output | 1 | The last multiply-accumulate wrapped |
| done_o | output | 1 | One-cycle pulse: the accumulator was just updated |
| xofs_o | output | 16 | Sign-extended X pointer step |
| yofs_o | output | 16 | Sign-extended Y pointer step |

## Verification
A wrong product or a bad sign extension shows up on acc_o in the same cycle as the done pulse for that operation. A corrupted accumulator keeps corrupting every later multiply-accumulate result until a clear, load or multiply-only operation replaces it. A mistimed pipeline register shows up as a done pulse that arrives too early, too late or with no matching start, or as an offset pair that belongs to a different start. The scoreboard catches each of these on the very next pulse. Guard-bit faults stay hidden until a sum passes ±1, so the test drives long chains of +1.0 products through the full range up to the wrap point.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

  typedef enum logic [1:0] {
    OP_CLR = 2'b00,
    OP_LD  = 2'b01,
    OP_MUL = 2'b10,
    OP_MAC = 2'b11
  } fmac_op_e;

endpackage

// File: rtl/fmac_mul_stage.sv
module fmac_mul_stage
  import fmac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  fmac_op_e                 op_i,
  input  logic [DATA_W-1:0]        opa_i,
  input  logic [DATA_W-1:0]        opb_i,
  output logic                     s1_valid_o,
  output fmac_op_e                 s1_op_o,
  output logic [2*DATA_W+EXT_W-1:0] s1_prod_o,
  output logic [2*DATA_W+EXT_W-1:0] s1_load_o
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + EXT_W;

  // Q15 x Q15 -> Q31 in a 33-bit frame, then sign-extended to the accumulator width.
  function automatic logic [ACC_W-1:0] q31_product(input logic signed [DATA_W-1:0] a,
                                                   input logic signed [DATA_W-1:0] b);
    logic signed [PROD_W-1:0] p;
    p = a * b;
    return {{(EXT_W-1){p[PROD_W-1]}}, p, 1'b0};
  endfunction

  // Two words form a 32-bit Q31 value, sign-extended.
  function automatic logic [ACC_W-1:0] load_value(input logic [DATA_W-1:0] hi,
                                                  input logic [DATA_W-1:0] lo);
    return {{EXT_W{hi[DATA_W-1]}}, hi, lo};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_o <= 1'b0;
      s1_op_o    <= OP_CLR;
      s1_prod_o  <= '0;
      s1_load_o  <= '0;
    end else begin
      s1_valid_o <= start_i;
      if (start_i) begin
        s1_op_o   <= op_i;
        s1_prod_o <= q31_product(opa_i, opb_i);
        s1_load_o <= load_value(opa_i, opb_i);
      end
    end
  end

endmodule

// File: rtl/fmac_acc_stage.sv
module fmac_acc_stage
  import fmac_pkg::*;
#(
  parameter int ACC_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid_i,
  input  fmac_op_e         s1_op_i,
  input  logic [ACC_W-1:0] s1_prod_i,
  input  logic [ACC_W-1:0] s1_load_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o,
  output logic             done_o,
  output logic             mac_fire_o,
  output logic             add_ovf_o
);

  // Wrapping add; the top bit of the result flags a sign error.
  function automatic logic [ACC_W:0] add_wrap(input logic [ACC_W-1:0] x,
                                              input logic [ACC_W-1:0] y);
    logic [ACC_W-1:0] s;
    logic             v;
    s = x + y;
    v = (x[ACC_W-1] == y[ACC_W-1]) && (s[ACC_W-1] != x[ACC_W-1]);
    return {v, s};
  endfunction

  logic [ACC_W:0]   sum_w;
  logic [ACC_W-1:0] acc_next;

  assign sum_w      = add_wrap(acc_o, s1_prod_i);
  assign mac_fire_o = s1_valid_i && (s1_op_i == OP_MAC);
  assign add_ovf_o  = mac_fire_o && sum_w[ACC_W];

  always_comb begin
    unique case (s1_op_i)
      OP_CLR:  acc_next = '0;
      OP_LD:   acc_next = s1_load_i;
      OP_MUL:  acc_next = s1_prod_i;
      default: acc_next = sum_w[ACC_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o  <= '0;
      ovf_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= s1_valid_i;
      if (s1_valid_i) begin
        acc_o <= acc_next;
        ovf_o <= add_ovf_o;
      end
    end
  end

endmodule

// File: rtl/fmac_ofs_unpack.sv
module fmac_ofs_unpack #(
  parameter int NIB_W = 4,
  parameter int PTR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [2*NIB_W-1:0] ofs_i,
  output logic [PTR_W-1:0]   xofs_o,
  output logic [PTR_W-1:0]   yofs_o
);

  logic [2*NIB_W-1:0] byte_q;
  logic [PTR_W-1:0]   step_w [2];

  function automatic logic [PTR_W-1:0] widen(input logic [NIB_W-1:0] n);
    return {{(PTR_W-NIB_W){n[NIB_W-1]}}, n};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (start_i) byte_q <= ofs_i;
  end

  // Index 1 = upper nibble (X), index 0 = lower nibble (Y).
  for (genvar g = 0; g < 2; g++) begin : g_nib
    logic [PTR_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= widen(byte_q[g*NIB_W +: NIB_W]);
    end
    assign step_w[g] = q;
  end

  assign xofs_o = step_w[1];
  assign yofs_o = step_w[0];

endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
  import fmac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 4,
  parameter int NIB_W  = 4,
  parameter int PTR_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [1:0]                op_i,
  input  logic [DATA_W-1:0]         opa_i,
  input  logic [DATA_W-1:0]         opb_i,
  input  logic [2*NIB_W-1:0]        ofs_i,
  output logic [2*DATA_W+EXT_W-1:0] acc_o,
  output logic                      ovf_o,
  output logic                      done_o,
  output logic [PTR_W-1:0]          xofs_o,
  output logic [PTR_W-1:0]          yofs_o
);

  localparam int ACC_W = 2 * DATA_W + EXT_W;

  logic             s1_valid;
  fmac_op_e         s1_op;
  logic [ACC_W-1:0] s1_prod;
  logic [ACC_W-1:0] s1_load;
  logic             mac_fire;
  logic             add_ovf;

  fmac_mul_stage #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_mul (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_i       (fmac_op_e'(op_i)),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .s1_valid_o (s1_valid),
    .s1_op_o    (s1_op),
    .s1_prod_o  (s1_prod),
    .s1_load_o  (s1_load)
  );

  fmac_acc_stage #(.ACC_W(ACC_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .s1_valid_i (s1_valid),
    .s1_op_i    (s1_op),
    .s1_prod_i  (s1_prod),
    .s1_load_i  (s1_load),
    .acc_o      (acc_o),
    .ovf_o      (ovf_o),
    .done_o     (done_o),
    .mac_fire_o (mac_fire),
    .add_ovf_o  (add_ovf)
  );

  fmac_ofs_unpack #(.NIB_W(NIB_W), .PTR_W(PTR_W)) u_ofs (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ofs_i   (ofs_i),
    .xofs_o  (xofs_o),
    .yofs_o  (yofs_o)
  );

endmodule

// File: rtl/fmac_unit_chk.sv
module fmac_unit_chk #(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 4,
  parameter int NIB_W  = 4,
  parameter int PTR_W  = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start_i,
  input logic [1:0]                op_i,
  input logic [2*NIB_W-1:0]        ofs_i,
  input logic [2*DATA_W+EXT_W-1:0] acc_o,
  input logic                      ovf_o,
  input logic                      done_o,
  input logic [PTR_W-1:0]          xofs_o,
  input logic [PTR_W-1:0]          yofs_o,
  input logic                      s1_valid,
  input logic                      mac_fire,
  input logic                      add_ovf
);

  // R7
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> done_o);

  // R7
  done_has_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i, 2));

  // R7
  acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(acc_o) && $stable(ovf_o)));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(op_i, 2) == 2'b00) |-> (acc_o == '0 && !ovf_o));

  // R6
  ovf_only_mac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ovf_o) |-> $past(op_i, 2) == 2'b11);

  // R6
  ovf_from_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_fire && add_ovf) |=> ovf_o);

  // R8
  xofs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> xofs_o[NIB_W-1:0] == $past(ofs_i[2*NIB_W-1:NIB_W], 2));

  // R8
  ofs_widen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones(yofs_o[PTR_W-1:NIB_W-1]) == 0 ||
                $countones(yofs_o[PTR_W-1:NIB_W-1]) == PTR_W-NIB_W+1));

endmodule

bind fmac_unit fmac_unit_chk #(
  .DATA_W(DATA_W), .EXT_W(EXT_W), .NIB_W(NIB_W), .PTR_W(PTR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .op_i     (op_i),
  .ofs_i    (ofs_i),
  .acc_o    (acc_o),
  .ovf_o    (ovf_o),
  .done_o   (done_o),
  .xofs_o   (xofs_o),
  .yofs_o   (yofs_o),
  .s1_valid (s1_valid),
  .mac_fire (mac_fire),
  .add_ovf  (add_ovf)
);

// File: tb/tb_fmac_unit.sv
module tb_fmac_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [15:0] opa_i = '0;
  logic [15:0] opb_i = '0;
  logic [7:0]  ofs_i = '0;
  logic [35:0] acc_o;
  logic        ovf_o;
  logic        done_o;
  logic [15:0] xofs_o;
  logic [15:0] yofs_o;

  fmac_unit dut (.*);

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    logic [35:0] acc;
    logic        ovf;
    logic [15:0] x;
    logic [15:0] y;
    string       req;
  } exp_t;

  exp_t   sb[$];
  int     checks = 0;
  int     errors = 0;
  longint model = 0;
  bit     finished = 0;

  localparam longint ACC_MAX = (longint'(1) << 35) - 1;
  localparam longint ACC_MIN = -(longint'(1) << 35);

  function automatic longint wrap36(input longint v);
    logic [35:0] t;
    t = v[35:0];
    return longint'($signed(t));
  endfunction

  function automatic logic [15:0] nib16(input logic [3:0] n);
    int v;
    v = (n >= 8) ? int'(n) - 16 : int'(n);
    return 16'(v);
  endfunction

  // Driver: one operation per call, on the next falling edge.
  task automatic issue(input logic [1:0] op, input logic [15:0] a,
                       input logic [15:0] b, input logic [7:0] ofs, input string req);
    exp_t   e;
    longint p, s;
    bit     v;
    p = longint'($signed(a)) * longint'($signed(b)) * 2;
    v = 1'b0;
    case (op)
      2'b00: model = 0;
      2'b01: model = longint'($signed({a, b}));
      2'b10: model = p;
      default: begin
        s = model + p;
        v = (s > ACC_MAX) || (s < ACC_MIN);
        model = wrap36(s);
      end
    endcase
    e.acc = model[35:0];
    e.ovf = v;
    e.x   = nib16(ofs[7:4]);
    e.y   = nib16(ofs[3:0]);
    e.req = req;
    @(negedge clk);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b; ofs_i = ofs;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    start_i = 1'b0; op_i = 2'b00; opa_i = 16'hDEAD; opb_i = 16'hBEEF; ofs_i = 8'h5A;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && !finished && done_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7", "done without start", 64'(done_o), 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(acc_o == e.acc, e.req, "acc", 64'(acc_o), 64'(e.acc));
        check(ovf_o == e.ovf, (e.ovf ? "R6" : e.req), "ovf", 64'(ovf_o), 64'(e.ovf));
        check(xofs_o == e.x && yofs_o == e.y, "R8", "offsets",
              {32'd0, xofs_o, yofs_o}, {32'd0, e.x, e.y});
      end
    end
  end

  // Watchdog
  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(acc_o == '0 && !ovf_o && !done_o && xofs_o == '0 && yofs_o == '0,
          "R9", "reset outputs", 64'(acc_o), 64'd0);
    rst_n = 1'b1;
    idle(2);
    check(!done_o, "R7", "no done when idle", 64'(done_o), 64'd0);

    issue(2'b10, 16'h4000, 16'h4000, 8'h71, "R1");   // 0.5*0.5
    issue(2'b10, 16'hC000, 16'h4000, 8'h8F, "R1");   // -0.5*0.5
    issue(2'b11, 16'h2000, 16'h2000, 8'h07, "R2");
    issue(2'b11, 16'h7FFF, 16'hFFFF, 8'hF8, "R2");
    idle(3);
    // R7: done must drop after one cycle with no new start
    check(!done_o, "R7", "done single pulse", 64'(done_o), 64'd0);

    issue(2'b10, 16'h8000, 16'h8000, 8'h00, "R3");
    idle(3);
    check(acc_o == 36'h0_8000_0000, "R3", "+1.0 encoding", 64'(acc_o), 64'h8_0000_000);
    issue(2'b00, 16'h1234, 16'h5678, 8'h12, "R4");
    issue(2'b01, 16'h8000, 16'h0001, 8'h34, "R5");
    issue(2'b01, 16'h7FFF, 16'hFFFF, 8'hE9, "R5");
    // Climb by +1.0 until the sum passes the top of the range.
    for (int i = 0; i < 16; i++) issue(2'b11, 16'h8000, 16'h8000, 8'(i * 17), "R2");
    issue(2'b11, 16'h0000, 16'h1234, 8'h00, "R6");  // no overflow clears flag
    issue(2'b00, 16'h0, 16'h0, 8'h00, "R4");
    // Descend by -1.0 past the bottom.
    for (int i = 0; i < 17; i++) issue(2'b11, 16'h8000, 16'h7FFF, 8'h9C, "R2");
    issue(2'b10, 16'h7FFF, 16'h7FFF, 8'h66, "R1");
    issue(2'b01, 16'hFFFF, 16'h8000, 8'hA5, "R5");
    idle(4);
    // Stable between operations (R7)
    begin
      logic [35:0] held;
      held = acc_o;
      idle(3);
      check(acc_o == held, "R7", "acc held while idle", 64'(acc_o), 64'(held));
    end
    check(sb.size() == 0, "R7", "missing done pulses", 64'(sb.size()), 64'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule